// File: doc/BRIEF.md
# Page Buffer Load Controller

This block gathers single-byte writes from a host into a one-page staging buffer. It then hands the whole page to a nonvolatile array in one programming operation. Each load carries a 17-bit byte address and an 8-bit value. The low seven address bits pick a slot in the 128-byte buffer, and the upper ten bits name the page. The host can keep a burst of loads open indefinitely, as long as no gap between two loads reaches the inactivity timeout.

Once the host has been silent for the full timeout, the block closes the burst and raises `busy` for a fixed programming interval. It cannot be interrupted during that interval. In the last cycle of the interval it presents the page image together with a commit strobe. It then refills the buffer with FFh and returns to idle.

The page that is written is always the page of the most recent load. Slots the host never touched are written as FFh. The value of the most recent accepted load is always available on `lastData`, so that a poller can compare against it.

Top module: `pageLoadCtrl`

## Requirements
- R1: After reset, `busy` and `commitValid` are 0 and `lastData` is 00h.
- R2: A byte loaded at address offset k (address bits 6..0) appears in `commitData[8k+7:8k]` of the commit that closes its burst.
- R3: `commitPage` carries address bits 16..7 of the last load in the burst. Every byte of the burst is committed to that page, whatever page its own load named.
- R4: Buffer slots not loaded during a burst are committed as FFh.
- R5: A later load to the same offset within one burst replaces the earlier value.
- R6: `busy` rises exactly TIMEOUT_CYC idle cycles after the last load of a burst. A load arriving after fewer than TIMEOUT_CYC idle cycles keeps the burst open.
- R7: `busy` stays high for exactly PROG_CYC cycles. `commitValid` is high only in the last of those cycles, and `busy` falls on the next cycle.
- R8: Loads presented while `busy` is high are ignored. They change neither `lastData` nor the committed image, and they do not open a new burst.
- R9: After a commit the buffer holds FFh in every slot, so a following burst does not inherit earlier data.
- R10: `lastData` equals the data of the most recent load accepted outside programming, from the cycle after that load onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadValid | input | 1 | Byte load request, one per cycle |
| loadAddr | input | 17 | Byte address: bits 16..7 page, bits 6..0 offset |
| loadData | input | 8 | Byte value to load |
| busy | output | 1 | High while the programming interval runs |
| commitValid | output | 1 | High in the final programming cycle; page image valid |
| commitPage | output | 10 | Page that the image is written to |
| commitData | output | 1024 | Page image, byte k at bits 8k+7..8k |
| lastData | output | 8 | Value of the most recent accepted load |

## Verification
The bench places a load exactly one cycle inside the timeout. A design that counts the window off by one would close the burst early and commit a page of FFh in place of the real data. A burst that crosses page boundaries checks that the whole image lands on the final page. A design that latched the first page would write the wrong page. Loads issued during programming check that neither the last-data value nor a new burst is disturbed. A follow-up burst reveals any buffer that is not refilled after a commit, because stale bytes would reappear in that burst's image.

// File: rtl/plc_pkg.sv
package plc_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrByte;   // store loadData in the slot addressed by loadAddr
    logic clrBuf;   // refill all slots with ones after commit
  } bufStrobe_t;
endpackage

// File: rtl/plcCtrl.sv
module plcCtrl
  import plc_pkg::*;
#(
  parameter int TIMEOUT_CYC = 10000,
  parameter int PROG_CYC    = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadValid,
  output bufStrobe_t strobe,
  output logic       busy,
  output logic       commitValid
);
  localparam int IDLE_W = $clog2(TIMEOUT_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} ctlState_t;

  ctlState_t          state;
  logic [IDLE_W-1:0]  idleCnt;
  logic [PROG_W-1:0]  progCnt;
  logic               lastProg;
  logic               idleDone;

  assign lastProg = (state == ST_PROG) && (progCnt == PROG_W'(PROG_CYC - 1));
  assign idleDone = (idleCnt == IDLE_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
      progCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (loadValid) begin
            state   <= ST_LOAD;
            idleCnt <= '0;
          end
        end
        ST_LOAD: begin
          if (loadValid) begin
            idleCnt <= '0;
          end else if (idleDone) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (lastProg) state <= ST_IDLE;
          else          progCnt <= progCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.wrByte = loadValid && (state != ST_PROG);
    strobe.clrBuf = lastProg;
  end

  assign busy        = (state == ST_PROG);
  assign commitValid = lastProg;
endmodule

// File: rtl/plcData.sv
module plcData
  import plc_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 128
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  bufStrobe_t                       strobe,
  input  logic [ADDR_W-1:0]                loadAddr,
  input  logic [DATA_W-1:0]                loadData,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commitPage,
  output logic [PAGE_BYTES*DATA_W-1:0]     commitData,
  output logic [DATA_W-1:0]                lastData
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [DATA_W-1:0] FILL = {DATA_W{1'b1}};

  logic [OFS_W-1:0] slotSel;
  assign slotSel = loadAddr[OFS_W-1:0];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    logic [DATA_W-1:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clrBuf)
        slotQ <= FILL;
      else if (strobe.wrByte && (slotSel == OFS_W'(g)))
        slotQ <= loadData;
    end
    assign commitData[g*DATA_W +: DATA_W] = slotQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commitPage <= '0;
      lastData   <= '0;
    end else if (strobe.wrByte) begin
      commitPage <= loadAddr[ADDR_W-1 -: PAGE_W];
      lastData   <= loadData;
    end
  end
endmodule

// File: rtl/pageLoadCtrl.sv
module pageLoadCtrl
  import plc_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 128,
  parameter int TIMEOUT_CYC = 10000,
  parameter int PROG_CYC    = 250000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  loadValid,
  input  logic [ADDR_W-1:0]                     loadAddr,
  input  logic [DATA_W-1:0]                     loadData,
  output logic                                  busy,
  output logic                                  commitValid,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  commitPage,
  output logic [PAGE_BYTES*DATA_W-1:0]          commitData,
  output logic [DATA_W-1:0]                     lastData
);
  localparam int PAGE_W = ADDR_W - $clog2(PAGE_BYTES);

  bufStrobe_t strobe;

  plcCtrl #(.TIMEOUT_CYC(TIMEOUT_CYC), .PROG_CYC(PROG_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid),
    .strobe(strobe), .busy(busy), .commitValid(commitValid)
  );

  plcData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .loadAddr(loadAddr), .loadData(loadData),
    .commitPage(commitPage), .commitData(commitData), .lastData(lastData)
  );
endmodule

// File: rtl/pageLoadCtrl_chk.sv
module pageLoadCtrl_chk #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadValid,
  input logic [DATA_W-1:0] loadData,
  input logic              busy,
  input logic              commitValid,
  input logic [PAGE_W-1:0] commitPage,
  input logic [DATA_W-1:0] lastData
);
  AST_COMMIT_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |-> busy); // R7
  AST_BUSY_DROP_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commitValid |=> !busy); // R7
  AST_BUSY_FALL_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(commitValid)); // R7
  AST_BUSY_RISE_AFTER_SILENCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(!loadValid)); // R6
  AST_LAST_HELD_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(lastData)); // R8
  AST_PAGE_HELD_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(commitPage)); // R8
  AST_LAST_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && !busy) |=> (lastData == $past(loadData))); // R10
endmodule

bind pageLoadCtrl pageLoadCtrl_chk #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) uChk (
  .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadData(loadData),
  .busy(busy), .commitValid(commitValid), .commitPage(commitPage),
  .lastData(lastData)
);

// File: tb/tb_pageLoadCtrl.sv
module tb_pageLoadCtrl;
  localparam int TO = 8;
  localparam int PR = 20;
  localparam int PB = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadValid = 1'b0;
  logic [16:0] loadAddr = '0;
  logic [7:0]  loadData = '0;
  logic        busy, commitValid;
  logic [9:0]  commitPage;
  logic [PB*8-1:0] commitData;
  logic [7:0]  lastData;

  always #10 clk = ~clk;

  pageLoadCtrl #(.TIMEOUT_CYC(TO), .PROG_CYC(PR)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadAddr(loadAddr),
    .loadData(loadData), .busy(busy), .commitValid(commitValid),
    .commitPage(commitPage), .commitData(commitData), .lastData(lastData)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model and flash array
  int mState = 0;  // 0 idle, 1 loading, 2 programming
  int mIdle = 0, mProg = 0, mPage = 0;
  logic [7:0] mLast = 8'h00;
  logic [7:0] img [PB];
  logic [7:0] flash [int];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mIdle = 0; mProg = 0; mPage = 0; mLast = 8'h00;
      for (int i = 0; i < PB; i++) img[i] = 8'hFF;
    end else begin
      if (mState == 2) begin
        if (mProg == PR - 1) begin
          for (int i = 0; i < PB; i++) img[i] = 8'hFF;
          mState = 0;
        end else mProg++;
      end else if (loadValid) begin
        img[int'(loadAddr[6:0])] = loadData;
        mPage = int'(loadAddr[16:7]);
        mLast = loadData;
        mIdle = 0;
        mState = 1;
      end else if (mState == 1) begin
        if (mIdle == TO - 1) begin mState = 2; mProg = 0; end
        else mIdle++;
      end
    end
    #5;
    if (rstN) begin
      chk("R6", "busy", 64'(busy), 64'(mState == 2));
      chk("R7", "commitValid", 64'(commitValid), 64'(mState == 2 && mProg == PR - 1));
      chk("R10", "lastData", 64'(lastData), 64'(mLast));
      if (mState == 2 && mProg == PR - 1) begin
        chk("R3", "commitPage", 64'(commitPage), 64'(mPage));
        for (int i = 0; i < PB; i++) begin
          chk("R2", "commit byte", 64'(commitData[i*8 +: 8]), 64'(img[i]));
          flash[int'(commitPage) * PB + i] = commitData[i*8 +: 8];
        end
      end
    end
  end

  function automatic logic [7:0] rdFlash(int page, int ofs);
    int k = page * PB + ofs;
    return flash.exists(k) ? flash[k] : 8'hxx;
  endfunction

  task automatic loadByte(int page, int ofs, logic [7:0] d);
    @(negedge clk);
    loadValid = 1'b1;
    loadAddr  = {10'(page), 7'(ofs)};
    loadData  = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic waitBusy();
    while (!busy) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 64'(busy), 64'd0);
    chk("R1", "commitValid after reset", 64'(commitValid), 64'd0);
    chk("R1", "lastData after reset", 64'(lastData), 64'h00);

    // burst on page 3, exact timeout edge
    loadByte(3, 0, 8'hA1);
    loadByte(3, 5, 8'h5B);
    loadByte(3, 127, 8'h7F);
    repeat (TO - 1) @(negedge clk);
    chk("R6", "busy one cycle before timeout", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R6", "busy at timeout", 64'(busy), 64'd1);
    waitIdle();
    chk("R2", "page3 ofs5", 64'(rdFlash(3, 5)), 64'h5B);
    chk("R2", "page3 ofs127", 64'(rdFlash(3, 127)), 64'h7F);
    chk("R2", "page3 ofs0", 64'(rdFlash(3, 0)), 64'hA1);
    chk("R4", "page3 ofs1 unloaded", 64'(rdFlash(3, 1)), 64'hFF);

    // burst across pages with a gap one cycle inside the window
    loadByte(5, 2, 8'h11);
    repeat (TO - 2) @(negedge clk);
    chk("R6", "burst still open", 64'(busy), 64'd0);
    loadByte(9, 4, 8'h22);
    loadByte(9, 4, 8'h33);
    loadByte(9, 9, 8'h44);
    waitBusy();
    waitIdle();
    chk("R3", "page5 byte on page9", 64'(rdFlash(9, 2)), 64'h11);
    chk("R3", "page5 not written", 64'(flash.exists(5 * PB + 2)), 64'd0);
    chk("R5", "overwrite wins", 64'(rdFlash(9, 4)), 64'h33);
    chk("R10", "lastData after burst", 64'(lastData), 64'h44);

    // loads during programming are ignored
    loadByte(12, 1, 8'h66);
    waitBusy();
    loadByte(12, 3, 8'h77);
    chk("R8", "lastData held in busy", 64'(lastData), 64'h66);
    waitIdle();
    chk("R8", "busy load not committed", 64'(rdFlash(12, 3)), 64'hFF);
    chk("R8", "burst load committed", 64'(rdFlash(12, 1)), 64'h66);
    repeat (TO + 4) @(negedge clk);
    chk("R8", "no burst from busy load", 64'(busy), 64'd0);

    // buffer cleared after commit
    loadByte(9, 0, 8'h88);
    waitBusy();
    waitIdle();
    chk("R9", "stale ofs4 cleared", 64'(rdFlash(9, 4)), 64'hFF);
    chk("R9", "stale ofs9 cleared", 64'(rdFlash(9, 9)), 64'hFF);
    chk("R2", "new byte ofs0", 64'(rdFlash(9, 0)), 64'h88);
    chk("R10", "lastData final", 64'(lastData), 64'h88);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule